// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block sits at the address input of a synchronous burst memory. On a clock edge where an address strobe is recognised it captures the external address and the state of three chip enables, then produces the address of each beat of a four-beat burst without further help from the bus master. Only the low two address bits move during a burst. They either count upward modulo four or follow an XOR pattern against the start offset. A static mode level picks the order.

Two active-low strobes can start an access. One belongs to the processor and one to a cache controller. The processor strobe has priority, and it is only recognised while the first, active-low chip enable is asserted. After the load, an active-low advance input steps the burst one beat per edge. Holding advance high freezes the address, which suspends the burst. The block also reports whether the last load selected the device and which strobe caused it. Every pin is a plain level control sampled on the rising edge. No stream crosses the edge of the block, so it has no valid/ready handshake and cannot apply back-pressure.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and after it is released with no strobe, mem_addr_o is 0, selected_o is 0 and proc_start_o is 0.
- R2: An edge with ads_proc_n=0 and ce1_n=0 loads addr_i. From then on mem_addr_o equals addr_i and proc_start_o is 1.
- R3: An edge with ads_ctrl_n=0 and no recognised processor strobe loads addr_i. From then on mem_addr_o equals addr_i and proc_start_o is 0.
- R4: When both strobes are low and ce1_n=0, the load is taken as a processor load (proc_start_o=1).
- R5: When ce1_n=1, ads_proc_n is ignored. With ads_ctrl_n=1 the edge does not reload the address and leaves selected_o and proc_start_o unchanged.
- R6: On a load, selected_o becomes 1 only when ce1_n=0, ce2=1 and ce3_n=0. Any other combination gives a deselect cycle with selected_o=0.
- R7: On edges that do not load, the chip enables have no effect on selected_o.
- R8: With mode_i=0 (linear), the low two bits of mem_addr_o at beat k (k=0..3 edges of advance after the load) are (start+k) mod 4.
- R9: With mode_i=1 (interleaved), the low two bits at beat k are start XOR k.
- R10: During a burst, mem_addr_o bits above bit 1 stay equal to the loaded address. After the fourth advance the low bits wrap back to the start offset.
- R11: An edge with no load and adv_n=1 leaves mem_addr_o unchanged (suspend). An edge with no load and adv_n=0 advances one beat.
- R12: mode_i is used as a live level: changing it mid-burst changes mem_addr_o at once to the other order for the same beat, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | External address, captured on a load |
| ads_proc_n | input | 1 | Processor address strobe, active low |
| ads_ctrl_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| mem_addr_o | output | ADDR_W | Current beat address |
| selected_o | output | 1 | Device selected by the last load |
| proc_start_o | output | 1 | Last load came from the processor strobe |

## Verification
The bench runs all four start offsets in both orders and continues past the fourth beat. A counter that saturates, or lets a carry reach bit 2, shows up there as a wrong wrap address. A suspend in the middle of a burst catches a design that advances without advance low. Simultaneous strobes catch a design that swaps priority, and a processor strobe under a high first chip enable catches one that reloads when it should ignore. Toggling the chip enables on continue cycles exposes a design that keeps sampling them. Flipping the mode mid-burst exposes one that latched the order at load time.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } src_e;
endpackage

// File: rtl/bag_strobe_arb.sv
module bag_strobe_arb
  import bag_pkg::*;
(
  input  logic ads_proc_n,
  input  logic ads_ctrl_n,
  input  logic ce1_n,
  input  logic ce2,
  input  logic ce3_n,
  output src_e src_o,
  output logic sel_next_o
);
  logic proc_seen;
  logic ctrl_seen;

  // processor strobe counts only while the first enable is asserted
  assign proc_seen = ~ads_proc_n & ~ce1_n;
  assign ctrl_seen = ~ads_ctrl_n;

  always_comb begin
    if (proc_seen)      src_o = SRC_PROC;
    else if (ctrl_seen) src_o = SRC_CTRL;
    else                src_o = SRC_NONE;
  end

  assign sel_next_o = ~ce1_n & ce2 & ~ce3_n;
endmodule

// File: rtl/bag_burst_ctr.sv
module bag_burst_ctr #(
  parameter int BURST_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               adv_n,
  output logic [BURST_W-1:0] beat_o
);
  localparam logic [BURST_W-1:0] ONE = BURST_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)       beat_o <= '0;
    else if (load_i)  beat_o <= '0;
    else if (!adv_n)  beat_o <= beat_o + ONE;
  end

  AST_BEAT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_n) |=> beat_o == $past(beat_o) + ONE); // R11
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && adv_n) |=> $stable(beat_o)); // R11
  AST_BEAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> beat_o == '0); // R2
endmodule

// File: rtl/bag_order.sv
module bag_order
  import bag_pkg::*;
#(
  parameter int BURST_W = 2
) (
  input  order_e             order_i,
  input  logic [BURST_W-1:0] start_i,
  input  logic [BURST_W-1:0] beat_i,
  output logic [BURST_W-1:0] low_o
);
  logic [BURST_W-1:0] lin_low;
  logic [BURST_W-1:0] xor_low;

  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < BURST_W; b++) begin : g_xor
    assign xor_low[b] = start_i[b] ^ beat_i[b];
  end

  assign low_o = (order_i == ORD_INTERLEAVE) ? xor_low : lin_low;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import bag_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ads_proc_n,
  input  logic              ads_ctrl_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_n,
  input  logic              mode_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              selected_o,
  output logic              proc_start_o
);
  localparam int HI_W = ADDR_W - BURST_W;

  src_e               src;
  logic               sel_next;
  logic               load;
  logic [HI_W-1:0]    hi_q;
  logic [BURST_W-1:0] start_q;
  logic [BURST_W-1:0] beat;
  logic [BURST_W-1:0] low;

  bag_strobe_arb u_arb (
    .ads_proc_n (ads_proc_n),
    .ads_ctrl_n (ads_ctrl_n),
    .ce1_n      (ce1_n),
    .ce2        (ce2),
    .ce3_n      (ce3_n),
    .src_o      (src),
    .sel_next_o (sel_next)
  );

  assign load = (src != SRC_NONE);

  bag_burst_ctr #(.BURST_W(BURST_W)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .adv_n  (adv_n),
    .beat_o (beat)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q         <= '0;
      start_q      <= '0;
      selected_o   <= 1'b0;
      proc_start_o <= 1'b0;
    end else if (load) begin
      hi_q         <= addr_i[ADDR_W-1:BURST_W];
      start_q      <= addr_i[BURST_W-1:0];
      selected_o   <= sel_next;
      proc_start_o <= (src == SRC_PROC);
    end
  end

  bag_order #(.BURST_W(BURST_W)) u_order (
    .order_i (order_e'(mode_i)),
    .start_i (start_q),
    .beat_i  (beat),
    .low_o   (low)
  );

  assign mem_addr_o = {hi_q, low};

  AST_PROC_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_proc_n && !ce1_n) |=> proc_start_o); // R4
  AST_CTRL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!ads_ctrl_n && ce1_n) |=> !proc_start_o); // R3
  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> mem_addr_o == $past(addr_i)); // R2
  AST_HI_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mem_addr_o[ADDR_W-1:BURST_W])); // R10
  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(selected_o) && $stable(proc_start_o)); // R7
  AST_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && adv_n) |=> (!$stable(mode_i) || $stable(mem_addr_o))); // R11
  AST_SEL_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && (ce1_n || !ce2 || ce3_n)) |=> !selected_o); // R6
endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb_top;
  localparam int AW = 17;
  localparam logic [AW-1:0] BASE = 17'h1A5C0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr_i;
  logic          ads_proc_n, ads_ctrl_n, ce1_n, ce2, ce3_n, adv_n, mode_i;
  logic [AW-1:0] mem_addr_o;
  logic          selected_o, proc_start_o;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BURST_W(2)) dut_i (
    .clk (clk), .rst_n (rst_n), .addr_i (addr_i),
    .ads_proc_n (ads_proc_n), .ads_ctrl_n (ads_ctrl_n),
    .ce1_n (ce1_n), .ce2 (ce2), .ce3_n (ce3_n),
    .adv_n (adv_n), .mode_i (mode_i),
    .mem_addr_o (mem_addr_o), .selected_o (selected_o),
    .proc_start_o (proc_start_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    ads_proc_n = 1'b1; ads_ctrl_n = 1'b1; adv_n = 1'b1;
  endtask

  // one edge, sampled at the following falling edge
  task automatic cycle();
    @(negedge clk);
  endtask

  task automatic good_ce();
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(); good_ce(); mode_i = 1'b0; addr_i = BASE;
    repeat (3) cycle();
    check("R1 addr in reset", 32'(mem_addr_o), 0);
    rst_n = 1'b1;
    cycle();
    check("R1 addr", 32'(mem_addr_o), 0);
    check("R1 selected", 32'(selected_o), 0);
    check("R1 proc flag", 32'(proc_start_o), 0);
  endtask

  task automatic t_burst(input logic md, input logic [1:0] st);
    logic [1:0] e;
    addr_i = BASE | AW'(st); mode_i = md; good_ce();
    ads_proc_n = 1'b0; adv_n = 1'b1;
    cycle();
    check("R2 load addr", 32'(mem_addr_o), 32'(BASE | AW'(st)));
    check("R2 proc flag", 32'(proc_start_o), 1);
    ads_proc_n = 1'b1; adv_n = 1'b0;
    addr_i = '0;
    for (int k = 1; k <= 4; k++) begin
      cycle();
      e = md ? (st ^ 2'(k)) : 2'(st + 2'(k));
      if (md) check("R9 interleave beat", 32'(mem_addr_o), 32'(BASE | AW'(e)));
      else    check("R8 linear beat", 32'(mem_addr_o), 32'(BASE | AW'(e)));
      if (k == 4) check("R10 wrap to start", 32'(mem_addr_o[1:0]), 32'(st));
    end
    check("R10 upper fixed", 32'(mem_addr_o[AW-1:2]), 32'(BASE[AW-1:2]));
    idle();
  endtask

  task automatic t_suspend();
    addr_i = BASE | 17'd1; mode_i = 1'b0; good_ce(); ads_proc_n = 1'b0;
    cycle();
    ads_proc_n = 1'b1; adv_n = 1'b0;
    cycle();
    check("R11 advance", 32'(mem_addr_o), 32'(BASE | 17'd2));
    adv_n = 1'b1;
    cycle(); cycle();
    check("R11 suspend hold", 32'(mem_addr_o), 32'(BASE | 17'd2));
    adv_n = 1'b0;
    cycle();
    check("R11 resume", 32'(mem_addr_o), 32'(BASE | 17'd3));
    idle();
  endtask

  task automatic t_priority();
    good_ce(); addr_i = BASE | 17'd3;
    ads_proc_n = 1'b0; ads_ctrl_n = 1'b0;
    cycle();
    check("R4 proc wins", 32'(proc_start_o), 1);
    idle(); addr_i = 17'h00AB4; ads_ctrl_n = 1'b0;
    cycle();
    check("R3 ctrl load addr", 32'(mem_addr_o), 32'h00AB4);
    check("R3 ctrl flag", 32'(proc_start_o), 0);
    check("R6 ctrl selected", 32'(selected_o), 1);
    idle();
  endtask

  task automatic t_ce1_ignore();
    good_ce(); addr_i = 17'h04000; ads_proc_n = 1'b0;
    cycle();
    idle(); ce1_n = 1'b1; ads_proc_n = 1'b0; addr_i = 17'h1FFF3;
    cycle();
    check("R5 no reload", 32'(mem_addr_o), 32'h04000);
    check("R5 selected kept", 32'(selected_o), 1);
    check("R5 flag kept", 32'(proc_start_o), 1);
    adv_n = 1'b0;
    cycle();
    check("R5 continue advances", 32'(mem_addr_o), 32'h04001);
    idle(); ads_ctrl_n = 1'b0;
    cycle();
    check("R6 ctrl with ce1 high deselects", 32'(selected_o), 0);
    check("R3 ctrl reload under ce1 high", 32'(mem_addr_o), 32'h1FFF3);
    idle(); good_ce();
  endtask

  task automatic t_deselect();
    good_ce(); ce2 = 1'b0; addr_i = BASE; ads_ctrl_n = 1'b0;
    cycle();
    check("R6 ce2 low deselect", 32'(selected_o), 0);
    idle(); good_ce(); ce3_n = 1'b1; ads_proc_n = 1'b0;
    cycle();
    check("R6 ce3 high deselect", 32'(selected_o), 0);
    check("R6 proc flag on deselect", 32'(proc_start_o), 1);
    idle(); good_ce(); ads_proc_n = 1'b0;
    cycle();
    check("R6 all enables select", 32'(selected_o), 1);
    idle();
  endtask

  task automatic t_ce_dontcare();
    ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1; adv_n = 1'b0;
    cycle();
    check("R7 enables ignored on continue", 32'(selected_o), 1);
    good_ce(); adv_n = 1'b1;
    cycle();
    good_ce(); ads_ctrl_n = 1'b0; ce2 = 1'b0;
    cycle();
    idle(); good_ce();
    cycle();
    check("R7 enables ignored after deselect", 32'(selected_o), 0);
  endtask

  task automatic t_mode_switch();
    good_ce(); mode_i = 1'b0; addr_i = BASE | 17'd1; ads_proc_n = 1'b0;
    cycle();
    ads_proc_n = 1'b1; adv_n = 1'b0;
    cycle();
    adv_n = 1'b1;
    check("R12 linear beat1", 32'(mem_addr_o), 32'(BASE | 17'd2));
    mode_i = 1'b1;
    #1;
    check("R12 interleave beat1 live", 32'(mem_addr_o), 32'(BASE | 17'd0));
    mode_i = 1'b0;
    #1;
    check("R12 back to linear", 32'(mem_addr_o), 32'(BASE | 17'd2));
    idle();
  endtask

  initial begin
    t_reset();
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        t_burst(1'(m), 2'(s));
    t_suspend();
    t_priority();
    t_ce1_ignore();
    t_deselect();
    t_ce_dontcare();
    t_mode_switch();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule